// File: doc/BRIEF.md
# Bridge Port Error Status Register

This block holds the 16-bit status word of a bus bridge port's configuration header. Six error flags record events reported by the bridge's transaction logic as one-cycle strobes. Once a flag is set it stays set until software clears it by writing a one to its bit position. Some flags latch every event. The system-error flag only latches while system-error reporting is enabled. The completion data-parity flag only latches while the parity-error response enable is on. The other bits of the word are fixed capability and decode-timing indications, or reserved zeros.

Software reads the word at any time: the read data is a combinational view of the flag state and the constant fields. A write carries a two-bit byte enable. Only the upper byte lane holds writable bits. Within that lane, each one in the write data clears the matching flag. If an event lands in the same cycle as a clear of its flag, the event wins.

Top module: `bridge_err_status`

## Requirements
- R1: After reset the register reads 0x0030.
- R2: Bits 5 and 4 always read 1. Bits 10, 9, 7, 6 and 3:0 always read 0. Writes and events never change these bits.
- R3: A strobe on `ev_bus_perr` sets bit 15 on the next clock edge, whatever the value of `perr_resp_en`.
- R4: A strobe on `ev_serr_sent` sets bit 14 only when `serr_rpt_en` is 1 in that cycle. When `serr_rpt_en` is 0 the strobe is ignored.
- R5: Strobes on `ev_mabort_rcvd`, `ev_tabort_rcvd` and `ev_tabort_sent` set bits 13, 12 and 11 respectively.
- R6: A strobe on `ev_cpl_perr` sets bit 8 only when `perr_resp_en` is 1 in that cycle. When `perr_resp_en` is 0 the strobe is ignored.
- R7: A set flag stays set while no clearing write targets it.
- R8: A write with `cfg_be[1]`=1 clears each flag in bits 15:11 and 8 whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R9: A write with `cfg_be[1]`=0 changes no flag, whatever `cfg_be[0]` and the write data are.
- R10: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: `cfg_rdata` follows the register state with no read latency. A flag set at a clock edge is visible before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 2 | Write byte enables; bit 1 covers bits 15:8 |
| cfg_wdata | input | 16 | Write data; ones clear flags |
| cfg_rdata | output | 16 | Current register contents |
| perr_resp_en | input | 1 | Parity-error response enable from the command word |
| serr_rpt_en | input | 1 | System-error reporting enable |
| ev_bus_perr | input | 1 | Address or data parity error seen upstream |
| ev_serr_sent | input | 1 | System error reported upstream |
| ev_mabort_rcvd | input | 1 | Completion with master-abort status received |
| ev_tabort_rcvd | input | 1 | Completion with target-abort status received |
| ev_tabort_sent | input | 1 | Completion with target-abort status generated |
| ev_cpl_perr | input | 1 | Parity error in a received completion |

## Verification
The hardest case to reach is an event strobe that lands in the same cycle as a write clearing the same flag. The stimulus table reaches it in two rows. One row pairs a clear of bit 14 with a system-error strobe while reporting is enabled. The other row writes all ones across both lanes while a target-abort-received strobe fires, and expects every flag to clear except bit 12. The gated flags are first struck with their enables off, so a wrongly gated flag shows up at the ports. They are then struck with the enables on.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int unsigned REG_W     = 16;
    localparam int unsigned BE_W      = REG_W / 8;
    localparam int unsigned NUM_FLAGS = 6;

    typedef enum logic [1:0] {
        GATE_NONE,
        GATE_SERR,
        GATE_PERR
    } gate_sel_e;

    // Flag index to bit position; index also orders the event vector.
    localparam int unsigned FLAG_POS [NUM_FLAGS] = '{15, 14, 13, 12, 11, 8};
    localparam gate_sel_e   FLAG_GATE[NUM_FLAGS] =
        '{GATE_NONE, GATE_SERR, GATE_NONE, GATE_NONE, GATE_NONE, GATE_PERR};

    localparam int unsigned CAP66_BIT   = 5;
    localparam int unsigned CAPLIST_BIT = 4;

    localparam logic [REG_W-1:0] RO_VAL =
        (REG_W'(1) << CAP66_BIT) | (REG_W'(1) << CAPLIST_BIT);

endpackage

// File: rtl/errstat_event_gate.sv
module errstat_event_gate
    import errstat_pkg::*;
#(
    parameter gate_sel_e GATE = GATE_NONE
) (
    input  logic ev,
    input  logic serr_en,
    input  logic perr_en,
    output logic set
);

    generate
        if (GATE == GATE_SERR) begin : g_serr
            logic unused_en;
            assign unused_en = perr_en;
            assign set = ev & serr_en;
        end else if (GATE == GATE_PERR) begin : g_perr
            logic unused_en;
            assign unused_en = serr_en;
            assign set = ev & perr_en;
        end else begin : g_none
            logic unused_en;
            assign unused_en = serr_en ^ perr_en;
            assign set = ev;
        end
    endgenerate

endmodule

// File: rtl/errstat_w1c_flag.sv
module errstat_w1c_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

endmodule

// File: rtl/errstat_readback.sv
module errstat_readback
    import errstat_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [REG_W-1:0]     rdata
);

    always_comb begin
        rdata = RO_VAL;
        for (int i = 0; i < NUM_FLAGS; i++)
            rdata[FLAG_POS[i]] = flags[i];
    end

endmodule

// File: rtl/bridge_err_status.sv
module bridge_err_status
    import errstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [BE_W-1:0]  cfg_be,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             perr_resp_en,
    input  logic             serr_rpt_en,
    input  logic             ev_bus_perr,
    input  logic             ev_serr_sent,
    input  logic             ev_mabort_rcvd,
    input  logic             ev_tabort_rcvd,
    input  logic             ev_tabort_sent,
    input  logic             ev_cpl_perr
);

    logic [NUM_FLAGS-1:0] ev_vec;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [REG_W-1:0]     lane_mask;
    logic [REG_W-1:0]     clr_mask;

    assign ev_vec = {ev_cpl_perr, ev_tabort_sent, ev_tabort_rcvd,
                     ev_mabort_rcvd, ev_serr_sent, ev_bus_perr};

    // Expand byte enables into a per-bit write mask.
    always_comb begin
        for (int b = 0; b < int'(REG_W); b++)
            lane_mask[b] = cfg_be[b / 8];
    end

    assign clr_mask = {REG_W{cfg_wr}} & lane_mask & cfg_wdata;

    logic unused_clr_bits;
    assign unused_clr_bits = ^clr_mask;

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            errstat_event_gate #(.GATE(FLAG_GATE[i])) u_gate (
                .ev      (ev_vec[i]),
                .serr_en (serr_rpt_en),
                .perr_en (perr_resp_en),
                .set     (set_vec[i])
            );

            assign clr_vec[i] = clr_mask[FLAG_POS[i]];

            errstat_w1c_flag #(.RST_VAL(1'b0)) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_vec[i]),
                .clr   (clr_vec[i]),
                .q     (flag_q[i])
            );
        end
    endgenerate

    errstat_readback u_rd (
        .flags (flag_q),
        .rdata (cfg_rdata)
    );

    // R4
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_rpt_en && !cfg_rdata[14]) |=> !cfg_rdata[14]);

    // R6
    cpl_perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_resp_en && !cfg_rdata[8]) |=> !cfg_rdata[8]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_be[1] && cfg_wdata[15] && !ev_bus_perr) |=> !cfg_rdata[15]);

    // R9
    lane_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_wr && cfg_be[1]) && cfg_rdata[13]) |=> cfg_rdata[13]);

    // R3
    perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_perr |=> cfg_rdata[15]);

endmodule

// File: tb/sim_bridge_err_status.sv
module sim_bridge_err_status;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_be;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        perr_resp_en;
    logic        serr_rpt_en;
    logic [5:0]  ev;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bridge_err_status u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr         (cfg_wr),
        .cfg_be         (cfg_be),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .perr_resp_en   (perr_resp_en),
        .serr_rpt_en    (serr_rpt_en),
        .ev_bus_perr    (ev[0]),
        .ev_serr_sent   (ev[1]),
        .ev_mabort_rcvd (ev[2]),
        .ev_tabort_rcvd (ev[3]),
        .ev_tabort_sent (ev[4]),
        .ev_cpl_perr    (ev[5])
    );

    // Row: {wr, be[1:0], wdata[15:0], perr_en, serr_en, ev[5:0], expected[15:0]}
    localparam int NV = 16;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b000001, 16'h8030}, // R3
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b000010, 16'h8030}, // R4 off
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b1, 6'b000010, 16'hC030}, // R4 on
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b100000, 16'hC030}, // R6 off
        {1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, 6'b100000, 16'hC130}, // R6 on
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b000100, 16'hE130}, // R5
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b001000, 16'hF130}, // R5
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b010000, 16'hF930}, // R5
        {1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 6'b000000, 16'hF930}, // R7
        {1'b1, 2'b01, 16'hFFFF, 1'b0, 1'b0, 6'b000000, 16'hF930}, // R9
        {1'b1, 2'b11, 16'h0000, 1'b0, 1'b0, 6'b000000, 16'hF930}, // R8 zeros
        {1'b1, 2'b10, 16'h8000, 1'b0, 1'b0, 6'b000000, 16'h7930}, // R8
        {1'b1, 2'b10, 16'h06B0, 1'b0, 1'b0, 6'b000000, 16'h7930}, // R2
        {1'b1, 2'b10, 16'h4000, 1'b0, 1'b1, 6'b000010, 16'h7930}, // R10
        {1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 6'b001000, 16'h1030}, // R10
        {1'b1, 2'b10, 16'h1000, 1'b0, 1'b0, 6'b000000, 16'h0030}  // R8
    };

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, cfg_rdata, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = 16'h0000;
        perr_resp_en = 1'b0; serr_rpt_en = 1'b0; ev = 6'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            finish_run();
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0030);

        for (int k = 0; k < NV; k++) begin
            cfg_wr       = VEC[k][42];
            cfg_be       = VEC[k][41:40];
            cfg_wdata    = VEC[k][39:24];
            perr_resp_en = VEC[k][23];
            serr_rpt_en  = VEC[k][22];
            ev           = VEC[k][21:16];
            @(negedge clk);
            idle();
            check($sformatf("R2/R3-R10 row %0d", k), VEC[k][15:0]);
        end

        // R11: visible just after the setting edge
        ev = 6'b010000;
        @(posedge clk);
        #1;
        ev = 6'b0;
        check("R11", 16'h0830);

        // R2: a full write to both lanes leaves the constant bits alone
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        idle();
        check("R2", 16'h0030);

        // R1: a reset in mid-run brings every flag back to zero
        ev = 6'b111111; perr_resp_en = 1'b1; serr_rpt_en = 1'b1;
        @(negedge clk);
        idle();
        check("R7", 16'hF930);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 16'h0030);

        finish_run();
    end

endmodule